// File: doc/BRIEF.md
# Reset Pin Conditioner

This block turns a raw, asynchronous, active-low reset pin into a clean active-low system reset for the bus fabric and peripherals. A free-running sampling clock samples the pin. The pin first passes through a synchronizer. A down-counter then measures how long the pin stays low without a break. A low stretch shorter than a glitch threshold is discarded, and so is any train of such stretches, because every high sample restarts the measurement. A low stretch that reaches the threshold qualifies as a real reset. The system reset then goes low and stays low for a guaranteed minimum width after the pin has come back high.

A second output carries a power-up-only reset. It serves always-on registers that a system reset must not clear. When the power-up input rises, both outputs go low at once, without waiting for a clock edge. When the power-up input falls, the power-up reset is released through a synchronizer. The system reset is released one stretch window later.

All time thresholds are parameters counted in sampling-clock cycles. The defaults assume a 200 MHz sampling clock: 30 cycles give 150 ns of glitch rejection, and 4000 cycles give a 20 µs minimum output pulse. The block has no data stream, so all its pins are plain control levels.

Top module: `rst_pin_conditioner`

## Requirements
- R1: `pin_n_i` is active low. A low level held for at least GLITCH_CYC consecutive sampling cycles drives `sys_rst_n_o` to 0. Counting the first rising edge that samples the pin low as edge 1, the output is 1 after edge GLITCH_CYC+2 and 0 after edge GLITCH_CYC+3.
- R2: A single low pulse that lasts fewer than GLITCH_CYC sampling cycles leaves `sys_rst_n_o` at 1 the whole time.
- R3: A train of low spikes, each shorter than GLITCH_CYC cycles and separated by at least one high sample, never asserts `sys_rst_n_o`. Each high sample restarts the low-time measurement.
- R4: While the pin stays low after a reset has qualified, `sys_rst_n_o` stays 0.
- R5: After a qualified reset, counting the first edge that samples the pin high again as edge 1, `sys_rst_n_o` is still 0 after edge STRETCH_CYC+3 and is 1 after edge STRETCH_CYC+4. Any low pulse on the output therefore lasts at least STRETCH_CYC cycles.
- R6: A second qualified low during the stretch window restarts the window from the second rise. An unqualified glitch during the window does not move the release.
- R7: While `por_i` is 1, both `sys_rst_n_o` and `por_rst_n_o` are 0, with no clock edge needed.
- R8: Counting the first rising edge after `por_i` falls as edge 1, `por_rst_n_o` is 0 after edge 1 and 1 after edge 2. `sys_rst_n_o` is 0 after edge STRETCH_CYC+2 and 1 after edge STRETCH_CYC+3.
- R9: Activity on `pin_n_i` never changes `por_rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running sampling clock |
| por_i | input | 1 | Power-up indication, active high, asynchronous |
| pin_n_i | input | 1 | Raw external reset pin, active low, asynchronous |
| sys_rst_n_o | output | 1 | Filtered and stretched system reset, active low |
| por_rst_n_o | output | 1 | Power-up-only reset, active low |

## Verification
Single low pulses of random length on both sides of the glitch threshold are checked cycle by cycle, including lengths of exactly GLITCH_CYC-1 and GLITCH_CYC. These separate the rejection path from the qualification path and pin down the exact assertion and release cycles. Random trains of short spikes with one- to four-cycle gaps show whether the measurement really restarts on every high sample rather than adding up low time. Directed cases cover the following:
- a long hold, to confirm the output stays low while the pin is low;
- a re-qualified low inside the stretch window, which must move the release;
- a short glitch inside the stretch window, which must not move it;
- a power-up pulse applied mid-cycle, which forces both outputs low at once and then releases the power-up reset and the system reset at their own separate edges.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
  // Defaults for a 200 MHz sampling clock
  localparam int DEF_GLITCH_CYC  = 30;    // 150 ns
  localparam int DEF_STRETCH_CYC = 4000;  // 20 us
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;
endpackage

// File: rtl/rstc_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer with asynchronous reset to a chosen value
module rstc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) shreg <= {STAGES{RST_VAL}};
    else           shreg <= {shreg[STAGES-2:0], d_i};
  end

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/rstc_width_filter.sv
`timescale 1ns/1ps
// Measures continuous low time; qualifies once GLITCH_CYC low samples accumulate
module rstc_width_filter #(
  parameter int GLITCH_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic lvl_n_i,
  output logic qual_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(GLITCH_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)              remain <= LOAD;
    else if (lvl_n_i)          remain <= LOAD;          // any high sample restarts
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign qual_o = (remain == '0);
endmodule

// File: rtl/rstc_stretch.sv
`timescale 1ns/1ps
// Holds the reset output low until STRETCH_CYC cycles pass with no qualification
module rstc_stretch #(
  parameter int STRETCH_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic qual_i,
  output logic rel_o
);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYC);

  logic [SW-1:0] hold;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)          hold <= LOAD;
    else if (qual_i)       hold <= LOAD;
    else if (hold != '0)   hold <= hold - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rel_q <= 1'b0;
    else          rel_q <= (hold == '0) && !qual_i;
  end

  assign rel_o = rel_q;
endmodule

// File: rtl/rst_pin_conditioner.sv
`timescale 1ns/1ps
module rst_pin_conditioner
  import rstc_pkg::*;
#(
  parameter int GLITCH_CYC  = DEF_GLITCH_CYC,
  parameter int STRETCH_CYC = DEF_STRETCH_CYC,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic sys_rst_n_o,
  output logic por_rst_n_o
);
  logic por_arst_n;
  logic por_n_sync;
  logic pin_sync;
  logic pin_qual;
  logic sys_rel;

  assign por_arst_n = ~por_i;

  // Power-up reset: asserted asynchronously, released synchronously
  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LVL_LOW)) u_por_sync (
    .clk_i    (clk_i),
    .arst_n_i (por_arst_n),
    .d_i      (1'b1),
    .q_o      (por_n_sync)
  );

  // Raw pin synchronizer, resets to the inactive (high) level
  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LVL_HIGH)) u_pin_sync (
    .clk_i    (clk_i),
    .arst_n_i (por_n_sync),
    .d_i      (pin_n_i),
    .q_o      (pin_sync)
  );

  rstc_width_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
    .clk_i   (clk_i),
    .rst_n_i (por_n_sync),
    .lvl_n_i (pin_sync),
    .qual_o  (pin_qual)
  );

  rstc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk_i   (clk_i),
    .rst_n_i (por_n_sync),
    .qual_i  (pin_qual),
    .rel_o   (sys_rel)
  );

  assign sys_rst_n_o = sys_rel;
  assign por_rst_n_o = por_n_sync;
endmodule

// File: rtl/rst_pin_conditioner_chk.sv
`timescale 1ns/1ps
module rst_pin_conditioner_chk #(
  parameter int STRETCH_CYC = 4000
) (
  input logic clk_i,
  input logic por_i,
  input logic sys_rst_n_o,
  input logic por_rst_n_o,
  input logic qual
);
  localparam int LW = $clog2(STRETCH_CYC + 2) + 1;
  localparam logic [LW-1:0] LMAX = '1;

  logic [LW-1:0] low_run;

  always_ff @(posedge clk_i or negedge por_rst_n_o) begin
    if (!por_rst_n_o)         low_run <= '0;
    else if (sys_rst_n_o)     low_run <= '0;
    else if (low_run != LMAX) low_run <= low_run + 1'b1;
  end

  AST_POR_FORCES_LOW: assert property (@(posedge clk_i)
    por_i |-> (!sys_rst_n_o && !por_rst_n_o)); // R7

  AST_SYS_UNDER_POR: assert property (@(posedge clk_i)
    !por_rst_n_o |-> !sys_rst_n_o); // R8

  AST_QUAL_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!por_rst_n_o)
    qual |=> !sys_rst_n_o); // R4

  AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!por_rst_n_o)
    $rose(sys_rst_n_o) |-> (low_run >= LW'(STRETCH_CYC))); // R5

  AST_NO_RELEASE_ON_QUAL: assert property (@(posedge clk_i) disable iff (!por_rst_n_o)
    $rose(sys_rst_n_o) |-> !$past(qual)); // R6

  AST_POR_STABLE: assert property (@(posedge clk_i) disable iff (por_i)
    por_rst_n_o |=> por_rst_n_o); // R9
endmodule

bind rst_pin_conditioner rst_pin_conditioner_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .sys_rst_n_o (sys_rst_n_o),
  .por_rst_n_o (por_rst_n_o),
  .qual        (pin_qual)
);

// File: tb/rst_pin_conditioner_bench.sv
`timescale 1ns/1ps
module rst_pin_conditioner_bench;
  localparam int G = 30;
  localparam int S = 4000;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic por_i = 1'b1;
  logic pin_n_i = 1'b1;
  logic sys_rst_n_o, por_rst_n_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_pin_conditioner #(.GLITCH_CYC(G), .STRETCH_CYC(S), .SYNC_STAGES(2)) u_rst_pin_conditioner (
    .clk_i(clk), .por_i(por_i), .pin_n_i(pin_n_i),
    .sys_rst_n_o(sys_rst_n_o), .por_rst_n_o(por_rst_n_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected system reset c edges after a lone pulse of length len starts
  function automatic logic exp_sys(input int len, input int c);
    if (len < G) return 1'b1;
    return !(c >= G + 3 && c < len + S + 4);
  endfunction

  function automatic string lbl(input int len, input int c);
    if (len < G) return "R2";
    if (c < G + 3) return "R1";
    if (c < len + 1) return "R4";
    return "R5";
  endfunction

  task automatic lone_pulse(input int len);
    int total;
    total = (len >= G) ? len + S + 6 : len + G + 6;
    pin_n_i = 1'b0;
    for (int c = 1; c <= total; c++) begin
      @(negedge clk);
      chk(lbl(len, c), sys_rst_n_o, exp_sys(len, c));
      chk("R9", por_rst_n_o, 1'b1);
      if (c == len) pin_n_i = 1'b1;
    end
  endtask

  task automatic spike_train(input int n);
    for (int i = 0; i < n; i++) begin
      int len, gap;
      len = int'($urandom_range(1, G - 1));
      gap = int'($urandom_range(1, 4));
      pin_n_i = 1'b0;
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        chk("R3", sys_rst_n_o, 1'b1);
      end
      pin_n_i = 1'b1;
      for (int c = 0; c < gap; c++) begin
        @(negedge clk);
        chk("R3", sys_rst_n_o, 1'b1);
      end
    end
    for (int c = 0; c < G + 5; c++) begin
      @(negedge clk);
      chk("R3", sys_rst_n_o, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd2419));
    #1;
    chk("R7", sys_rst_n_o, 1'b0);
    chk("R7", por_rst_n_o, 1'b0);
    edges(3);
    chk("R7", por_rst_n_o, 1'b0);

    // power-up release
    por_i = 1'b0;
    edges(1); chk("R8", por_rst_n_o, 1'b0);
    edges(1); chk("R8", por_rst_n_o, 1'b1);
    edges(S); chk("R8", sys_rst_n_o, 1'b0);
    edges(1); chk("R8", sys_rst_n_o, 1'b1);
    edges(5);

    // directed boundaries
    lone_pulse(G - 1);
    lone_pulse(G);
    lone_pulse(3 * G);
    lone_pulse(1);

    // random single pulses around the threshold
    for (int i = 0; i < 8; i++) lone_pulse(int'($urandom_range(1, 2 * G)));

    // glitch trains
    spike_train(20);
    spike_train(40);

    // re-qualification inside stretch window
    pin_n_i = 1'b0; edges(G + 5);
    pin_n_i = 1'b1; edges(50);
    pin_n_i = 1'b0; edges(G + 2);
    pin_n_i = 1'b1;
    edges(S - G - 48); chk("R6", sys_rst_n_o, 1'b0);
    edges(G + 51);     chk("R6", sys_rst_n_o, 1'b0);
    edges(1);          chk("R6", sys_rst_n_o, 1'b1);
    edges(G + 5);

    // unqualified glitch inside stretch window
    pin_n_i = 1'b0; edges(G + 5);
    pin_n_i = 1'b1; edges(100);
    pin_n_i = 1'b0; edges(G - 1);
    pin_n_i = 1'b1;
    edges(S + 3 - (G + 99)); chk("R6", sys_rst_n_o, 1'b0);
    edges(1);                chk("R6", sys_rst_n_o, 1'b1);
    edges(G + 5);

    // power-up pulse mid-cycle
    #1 por_i = 1'b1;
    #1;
    chk("R7", sys_rst_n_o, 1'b0);
    chk("R7", por_rst_n_o, 1'b0);
    @(negedge clk);
    por_i = 1'b0;
    edges(1); chk("R8", por_rst_n_o, 1'b0);
    edges(1); chk("R8", por_rst_n_o, 1'b1);
    edges(S); chk("R8", sys_rst_n_o, 1'b0);
    edges(1); chk("R8", sys_rst_n_o, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule